// File: doc/BRIEF.md
# Three-Wire Synthesizer Programming Interface

This block is the control front end of a dual-loop frequency synthesizer. A host shifts 24-bit words in over a slow three-line bus made of a bit clock, a data line and a strobe. The bus lines are sampled in the system clock domain, and edges on the bit clock and the strobe are detected there. Each word carries an address in its top bits. When the strobe rises, the payload is written into the working registers that the selected address names. Those registers drive the main, auxiliary and reference dividers, the lock output selector, the charge-pump settings and the power controls.

Two behaviours tie words together. The fractional-compensation DAC code carried by a B word is held in a staging register and only reaches its output when the next A word is latched. Latching an A word also opens a charge-pump speed-up window, which closes when the strobe falls. A test bit can hold speed-up on permanently. The power enables are the hardware power pin combined by XOR with the software power bits, so the pin can invert the sense of the software bits.

Top module: `synth_prog_if`

## Requirements
- R1: Words are 24 bits long and the least significant bit is shifted first. Bit 23 is the last bit clocked in, and a data bit is taken on each rising edge of the bus clock.
- R2: The address in bits 23:22 selects the word type: 00 is A, 01 is B and 10 is C. A: bit 21 is mod5_o (1 = modulo 5, 0 = modulo 8), bits 20:18 are frac_inc_o, bits 17:2 are main_ratio_o and bits 1:0 are spare. B: bits 21:12 are ref_ratio_o, bits 11:10 are lock_mode_o, bit 9 is the main power bit, bit 8 is the aux power bit and bits 7:0 are the staged DAC code. C: bits 21:8 are aux_ratio_o, bits 7:6 are cp_sel_o, bits 5:3 are main_cmp_sel_o and bits 2:0 are aux_cmp_sel_o.
- R3: While the strobe is high, bus clock edges do not shift, so the shift register contents stay frozen.
- R4: Working registers change only on a rising edge of the strobe, from the word held in the shift register.
- R5: The B word's DAC bits go to a staging register only. dac_o takes the staged value when the next A word is latched, and at no other time.
- R6: speedup_o rises when an A word is latched and stays high while the strobe is high. It falls when the strobe falls, unless the test bit is set.
- R7: A word with bits 23:21 = 110 (D word) loads bit 0 as the test bit. When the test bit is 1, speedup_o is 1 at all times.
- R8: main_on_o equals pwr_pin_i XOR the main power bit, and aux_on_o equals pwr_pin_i XOR the aux power bit.
- R9: After reset, the outputs hold these defaults: mod5 0, frac_inc 0, main ratio DEF_MAIN_RATIO (2000), ref ratio DEF_REF_RATIO (26), lock mode 0, both power bits 1, DAC DEF_DAC (80), aux ratio DEF_AUX_RATIO (1000), cp/sm/sa 0, test bit 0, speedup_o 0.
- R10: A word whose bits 23:21 are 111 leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_clk_i | input | 1 | Serial bit clock (asynchronous) |
| bus_data_i | input | 1 | Serial data |
| bus_strobe_i | input | 1 | Word strobe: high freezes shifting, rising edge latches |
| pwr_pin_i | input | 1 | Hardware power polarity pin |
| mod5_o | output | 1 | Fractional modulus select |
| frac_inc_o | output | 3 | Fractional increment |
| main_ratio_o | output | 16 | Main divide ratio |
| ref_ratio_o | output | 10 | Reference divide ratio |
| lock_mode_o | output | 2 | Lock output mode |
| main_on_o | output | 1 | Effective main loop power enable |
| aux_on_o | output | 1 | Effective aux loop power enable |
| dac_o | output | 8 | Working fractional-compensation DAC code |
| aux_ratio_o | output | 14 | Auxiliary divide ratio |
| cp_sel_o | output | 2 | Charge-pump current select |
| main_cmp_sel_o | output | 3 | Main comparison tap select |
| aux_cmp_sel_o | output | 3 | Aux comparison tap select |
| speedup_o | output | 1 | Charge-pump speed-up request |

## Verification
The bench builds the block with SYNC_STAGES = 3 and a main-ratio default of 4660. This checks that the reset value follows the parameter and that edge detection still orders clock, data and strobe correctly through a deeper synchronizer. Bus phases are held five system cycles each. With that spacing, the bench can see speed-up during the strobe-high window and can check that extra bit clocks sent while the strobe is high are ignored, by re-strobing the frozen word. Random words of all five address classes, including the unrecognised one, are then run against a bench model that tracks the DAC staging.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
  localparam int WORD_W = 24;
  localparam int ADDR_W = 2;
  localparam int EXT_ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADR_A   = 2'b00,
    ADR_B   = 2'b01,
    ADR_C   = 2'b10,
    ADR_EXT = 2'b11
  } addr_e;

  localparam logic [EXT_ADDR_W-1:0] ADR_D = 3'b110;

  typedef struct packed {
    logic        mod5;
    logic [2:0]  frac_inc;
    logic [15:0] main_ratio;
    logic [9:0]  ref_ratio;
    logic [1:0]  lock_mode;
    logic        main_pwr;
    logic        aux_pwr;
    logic [7:0]  dac;
    logic [13:0] aux_ratio;
    logic [1:0]  cp_sel;
    logic [2:0]  main_cmp_sel;
    logic [2:0]  aux_cmp_sel;
    logic        tspu;
  } cfg_t;
endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
  parameter int STAGES = 2,
  parameter int W      = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '0;
    end else begin
      pipe_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/word_shifter.sv
module word_shifter #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_en_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         word_o <= '0;
    else if (shift_en_i) word_o <= {bit_i, word_o[W-1:1]};  // lsb first
  end
endmodule

// File: rtl/prog_regs.sv
module prog_regs
  import synth_prog_pkg::*;
#(
  parameter cfg_t DEFAULTS = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              latch_i,
  input  logic              strobe_fall_i,
  input  logic [WORD_W-1:0] word_i,
  output cfg_t              cfg_o,
  output logic              speedup_o
);
  addr_e      addr;
  logic [2:0] ext_addr;
  logic [7:0] dac_stage_q;
  logic       spd_win_q;
  cfg_t       cfg_q;

  assign addr     = addr_e'(word_i[WORD_W-1 -: ADDR_W]);
  assign ext_addr = word_i[WORD_W-1 -: EXT_ADDR_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q       <= DEFAULTS;
      dac_stage_q <= DEFAULTS.dac;
    end else if (latch_i) begin
      unique case (addr)
        ADR_A: begin
          cfg_q.mod5       <= word_i[21];
          cfg_q.frac_inc   <= word_i[20:18];
          cfg_q.main_ratio <= word_i[17:2];
          cfg_q.dac        <= dac_stage_q;
        end
        ADR_B: begin
          cfg_q.ref_ratio <= word_i[21:12];
          cfg_q.lock_mode <= word_i[11:10];
          cfg_q.main_pwr  <= word_i[9];
          cfg_q.aux_pwr   <= word_i[8];
          dac_stage_q     <= word_i[7:0];
        end
        ADR_C: begin
          cfg_q.aux_ratio    <= word_i[21:8];
          cfg_q.cp_sel       <= word_i[7:6];
          cfg_q.main_cmp_sel <= word_i[5:3];
          cfg_q.aux_cmp_sel  <= word_i[2:0];
        end
        ADR_EXT: begin
          if (ext_addr == ADR_D) cfg_q.tspu <= word_i[0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     spd_win_q <= 1'b0;
    else if (latch_i && addr == ADR_A) spd_win_q <= 1'b1;
    else if (strobe_fall_i)          spd_win_q <= 1'b0;
  end

  assign cfg_o     = cfg_q;
  assign speedup_o = spd_win_q | cfg_q.tspu;

  AST_DAC_ONLY_ON_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_q.dac) |-> $past(latch_i && addr == ADR_A)); // R5
  AST_WRITE_ON_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_q) |-> $past(latch_i)); // R4
  AST_BAD_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_i && ext_addr == 3'b111) |=> $stable(cfg_q)); // R10
  AST_SPDUP_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_fall_i && !cfg_q.tspu) |=> !speedup_o); // R6
endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if
  import synth_prog_pkg::*;
#(
  parameter int          SYNC_STAGES    = 2,
  parameter logic [15:0] DEF_MAIN_RATIO = 16'd2000,
  parameter logic [9:0]  DEF_REF_RATIO  = 10'd26,
  parameter logic [13:0] DEF_AUX_RATIO  = 14'd1000,
  parameter logic [7:0]  DEF_DAC        = 8'd80
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_clk_i,
  input  logic        bus_data_i,
  input  logic        bus_strobe_i,
  input  logic        pwr_pin_i,
  output logic        mod5_o,
  output logic [2:0]  frac_inc_o,
  output logic [15:0] main_ratio_o,
  output logic [9:0]  ref_ratio_o,
  output logic [1:0]  lock_mode_o,
  output logic        main_on_o,
  output logic        aux_on_o,
  output logic [7:0]  dac_o,
  output logic [13:0] aux_ratio_o,
  output logic [1:0]  cp_sel_o,
  output logic [2:0]  main_cmp_sel_o,
  output logic [2:0]  aux_cmp_sel_o,
  output logic        speedup_o
);
  localparam cfg_t DEF_CFG = '{
    mod5: 1'b0, frac_inc: 3'd0, main_ratio: DEF_MAIN_RATIO,
    ref_ratio: DEF_REF_RATIO, lock_mode: 2'd0, main_pwr: 1'b1,
    aux_pwr: 1'b1, dac: DEF_DAC, aux_ratio: DEF_AUX_RATIO,
    cp_sel: 2'd0, main_cmp_sel: 3'd0, aux_cmp_sel: 3'd0, tspu: 1'b0};

  logic [2:0]        sync_q;
  logic              s_clk, s_data, s_strobe;
  logic              clk_d, strobe_d;
  logic              clk_rise, strobe_rise, strobe_fall;
  logic [WORD_W-1:0] word;
  cfg_t              cfg;

  bus_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({bus_strobe_i, bus_data_i, bus_clk_i}),
    .q_o   (sync_q)
  );
  assign {s_strobe, s_data, s_clk} = sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_d    <= 1'b0;
      strobe_d <= 1'b0;
    end else begin
      clk_d    <= s_clk;
      strobe_d <= s_strobe;
    end
  end

  assign clk_rise    = s_clk & ~clk_d;
  assign strobe_rise = s_strobe & ~strobe_d;
  assign strobe_fall = ~s_strobe & strobe_d;

  word_shifter #(.W(WORD_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shift_en_i(clk_rise & ~s_strobe),
    .bit_i     (s_data),
    .word_o    (word)
  );

  prog_regs #(.DEFAULTS(DEF_CFG)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .latch_i      (strobe_rise),
    .strobe_fall_i(strobe_fall),
    .word_i       (word),
    .cfg_o        (cfg),
    .speedup_o    (speedup_o)
  );

  assign mod5_o         = cfg.mod5;
  assign frac_inc_o     = cfg.frac_inc;
  assign main_ratio_o   = cfg.main_ratio;
  assign ref_ratio_o    = cfg.ref_ratio;
  assign lock_mode_o    = cfg.lock_mode;
  assign dac_o          = cfg.dac;
  assign aux_ratio_o    = cfg.aux_ratio;
  assign cp_sel_o       = cfg.cp_sel;
  assign main_cmp_sel_o = cfg.main_cmp_sel;
  assign aux_cmp_sel_o  = cfg.aux_cmp_sel;
  assign main_on_o      = pwr_pin_i ^ cfg.main_pwr;
  assign aux_on_o       = pwr_pin_i ^ cfg.aux_pwr;

  AST_FROZEN_ON_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_strobe |=> $stable(word)); // R3
  AST_LATCH_NEEDS_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg) |-> $past(s_strobe)); // R4
endmodule

// File: tb/synth_prog_if_test.sv
module synth_prog_if_test;
  import synth_prog_pkg::*;

  localparam int HOLD = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bclk = 1'b0, bdata = 1'b0, bstb = 1'b0, pin = 1'b0;
  logic        mod5, main_on, aux_on, spd;
  logic [2:0]  frac, msel, asel;
  logic [15:0] mratio;
  logic [9:0]  rratio;
  logic [1:0]  lmode, cpsel;
  logic [7:0]  dac;
  logic [13:0] aratio;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  cfg_t exp_c, act_c;
  logic [7:0] exp_stage;
  logic spd_hi;

  always #5 clk = ~clk;

  synth_prog_if #(.SYNC_STAGES(3), .DEF_MAIN_RATIO(16'd4660)) uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_clk_i(bclk), .bus_data_i(bdata),
    .bus_strobe_i(bstb), .pwr_pin_i(pin), .mod5_o(mod5), .frac_inc_o(frac),
    .main_ratio_o(mratio), .ref_ratio_o(rratio), .lock_mode_o(lmode),
    .main_on_o(main_on), .aux_on_o(aux_on), .dac_o(dac), .aux_ratio_o(aratio),
    .cp_sel_o(cpsel), .main_cmp_sel_o(msel), .aux_cmp_sel_o(asel), .speedup_o(spd)
  );

  always_comb begin
    act_c = '{mod5: mod5, frac_inc: frac, main_ratio: mratio, ref_ratio: rratio,
              lock_mode: lmode, main_pwr: main_on ^ pin, aux_pwr: aux_on ^ pin,
              dac: dac, aux_ratio: aratio, cp_sel: cpsel, main_cmp_sel: msel,
              aux_cmp_sel: asel, tspu: 1'b0};
  end

  task automatic chk(string tag, logic [95:0] act, logic [95:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  // bench model of the word decode
  task automatic model(logic [23:0] w);
    case (w[23:22])
      2'b00: begin
        exp_c.mod5 = w[21]; exp_c.frac_inc = w[20:18];
        exp_c.main_ratio = w[17:2]; exp_c.dac = exp_stage;
      end
      2'b01: begin
        exp_c.ref_ratio = w[21:12]; exp_c.lock_mode = w[11:10];
        exp_c.main_pwr = w[9]; exp_c.aux_pwr = w[8]; exp_stage = w[7:0];
      end
      2'b10: begin
        exp_c.aux_ratio = w[21:8]; exp_c.cp_sel = w[7:6];
        exp_c.main_cmp_sel = w[5:3]; exp_c.aux_cmp_sel = w[2:0];
      end
      default: if (w[21] == 1'b0) exp_c.tspu = w[0];
    endcase
  endtask

  task automatic shift_bits(logic [23:0] w, int n);
    for (int i = 0; i < n; i++) begin
      bdata = w[i];
      wait_n(HOLD); bclk = 1'b1;
      wait_n(HOLD); bclk = 1'b0;
    end
  endtask

  // extra > 0 sends bit clocks of ones while strobe is high
  task automatic send_word(logic [23:0] w, int extra);
    bstb = 1'b0;
    shift_bits(w, 24);
    wait_n(HOLD); bstb = 1'b1;
    wait_n(3 * HOLD);
    spd_hi = spd;
    if (extra > 0) shift_bits(24'hFFFFFF, extra);
    bstb = 1'b0;
    wait_n(3 * HOLD);
    model(w);
  endtask

  function automatic logic [95:0] cmpv(cfg_t c);
    cfg_t t = c;
    t.tspu = 1'b0;
    return 96'(t);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    exp_c = '{mod5: 1'b0, frac_inc: 3'd0, main_ratio: 16'd4660, ref_ratio: 10'd26,
              lock_mode: 2'd0, main_pwr: 1'b1, aux_pwr: 1'b1, dac: 8'd80,
              aux_ratio: 14'd1000, cp_sel: 2'd0, main_cmp_sel: 3'd0,
              aux_cmp_sel: 3'd0, tspu: 1'b0};
    exp_stage = 8'd80;
    wait_n(4); rst_n = 1'b1; wait_n(2);
    chk("R9 reset fields", cmpv(act_c), cmpv(exp_c));
    chk("R9 reset speedup", 96'(spd), 96'(0));
    chk("R9 R8 reset power on", 96'({main_on, aux_on}), 96'(2'b11));

    // R1 R2: A word, distinct pattern; R6 speed-up window
    send_word({2'b00, 1'b1, 3'b101, 16'hA5C3, 2'b10}, 0);
    chk("R1 R2 A word fields", cmpv(act_c), cmpv(exp_c));
    chk("R6 speedup high after A latch", 96'(spd_hi), 96'(1));
    chk("R6 speedup low after strobe fall", 96'(spd), 96'(0));

    // R5: B word stages DAC only
    send_word({2'b01, 10'd777, 2'b10, 1'b0, 1'b1, 8'hC7}, 0);
    chk("R2 B word fields", cmpv(act_c), cmpv(exp_c));
    chk("R5 dac held after B", 96'(dac), 96'(80));
    chk("R6 no speedup on B", 96'(spd_hi), 96'(0));
    send_word({2'b00, 1'b0, 3'b011, 16'd1234, 2'b00}, 0);
    chk("R5 dac moved on A", 96'(dac), 96'(8'hC7));

    // R8 power pin inverts sense
    pin = 1'b1; wait_n(2);
    chk("R8 pin high power", 96'({main_on, aux_on}), 96'(2'b10));
    pin = 1'b0; wait_n(2);
    chk("R8 pin low power", 96'({main_on, aux_on}), 96'(2'b01));

    // R3: clocks during strobe ignored; re-strobe the frozen word
    send_word({2'b10, 14'd9001, 2'b01, 3'b110, 3'b011}, 7);
    chk("R2 C word fields", cmpv(act_c), cmpv(exp_c));
    bstb = 1'b1; wait_n(3 * HOLD); bstb = 1'b0; wait_n(3 * HOLD);
    chk("R3 frozen word re-latched", cmpv(act_c), cmpv(exp_c));

    // R10 unrecognised address
    send_word({3'b111, 21'h1FFFFF}, 0);
    chk("R10 bad address ignored", cmpv(act_c), cmpv(exp_c));
    chk("R10 bad address no speedup", 96'(spd), 96'(0));

    // R7 test bit
    send_word({3'b110, 20'd0, 1'b1}, 0);
    chk("R7 tspu forces speedup", 96'(spd), 96'(1));
    send_word({2'b00, 22'h3ABCD}, 0);
    chk("R7 speedup stays after strobe fall", 96'(spd), 96'(1));
    send_word({3'b110, 21'd0}, 0);
    chk("R7 tspu cleared", 96'(spd), 96'(0));

    // random words of all address classes
    for (int k = 0; k < 60; k++) begin
      logic [23:0] w;
      int sel;
      w = 24'($urandom);
      sel = $urandom_range(0, 4);
      case (sel)
        0: w[23:22] = 2'b00;
        1: w[23:22] = 2'b01;
        2: w[23:22] = 2'b10;
        3: begin w[23:21] = 3'b110; w[0] = ($urandom_range(0, 3) == 0); end
        default: w[23:21] = 3'b111;
      endcase
      send_word(w, 0);
      chk("R1 R2 R5 R10 random word", cmpv(act_c), cmpv(exp_c));
      chk("R6 R7 random speedup", 96'(spd), 96'(exp_c.tspu));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule